// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block is a first-level interrupt controller. It collects a parameterised number of level-sensitive peripheral interrupt lines (32, 64 or 128) and drives one interrupt output per CPU. Each CPU owns a separate bank of 32-bit enable and status words. A source reaches a CPU only when that CPU's enable bit for it is set, so a source can be steered to one CPU, to several, or to none.

A simple word-addressed register port gives access to every bank. It has an address, a write strobe, write data and combinational read data. Each bank holds `NUM_SRC/32` enable words followed by the same number of status words. Banks are laid out back to back, one bank per CPU index. There is no priority encoding. Software reads every status word of its bank to find the pending sources. Input lines pass through a two-flop synchroniser before use.

Top module: `l1_irq_agg`

## Requirements
- R1: After reset every enable bit is zero, every `irq_o` bit is low, and every register reads zero.
- R2: A write to word offset k of a bank, with k below `NUM_SRC/32`, replaces enable word k of that bank with the full 32-bit write data. A later read of the same address returns that value.
- R3: Reading word offset `NUM_SRC/32 + k` of a bank returns the synchronised source levels for word k ANDed with that bank's enable word k. A change on `irq_i` first becomes visible there after the second rising clock edge.
- R4: Writes to status offsets are ignored. Enable and status contents are unchanged afterwards.
- R5: `irq_o[c]` is a registered OR of all status bits of bank c. It rises one edge after a status bit becomes set, and it falls one edge after the last source drops or the last enable is cleared.
- R6: A write to bank c changes no enable bit in any other bank.
- R7: Word addresses at or above `NUM_CPU * 2 * NUM_SRC/32` read zero, and writes to them change no register.
- R8: Bit n of enable word k and bit n of status word k both belong to source `32*k + n`.
- R9: Bank c occupies word addresses starting at `c * 2 * NUM_SRC/32`, with enable words at offsets 0 to `NUM_SRC/32 - 1` and status words after them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_SRC | Level interrupt sources, may be asynchronous |
| addr_i | input | ADDR_W | Word address of register access |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | NUM_CPU | Interrupt output per CPU |

## Verification
The assertions assume that `addr_i`, `we_i` and `wdata_i` are synchronous to `clk_i` and stable around each rising edge. The `irq_i` lines may change at any time, because only their synchronised copies take part in the checked relations. The stimulus changes every input at the falling edge, so each access and each source change is seen exactly once by the design and by the reference model. The stimulus also covers the second-edge latency of a source change, status writes, out-of-range banks and randomly mixed traffic.

// File: rtl/l1_agg_pkg.sv
package l1_agg_pkg;
  parameter int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/l1_sync.sv
module l1_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/l1_bank.sv
module l1_bank
  import l1_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned NW    = NUM_SRC / WORD_W,
  localparam int unsigned OFF_W = $clog2(2 * NW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] level_i,
  input  logic               we_i,
  input  logic [OFF_W-1:0]   off_i,
  input  word_t              wdata_i,
  output word_t              rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] pend;
  logic               irq_q;

  assign pend = level_i & en_q;

  for (genvar k = 0; k < NW; k++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             en_q[k*WORD_W +: WORD_W] <= '0;
      else if (we_i && off_i == OFF_W'(k))     en_q[k*WORD_W +: WORD_W] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NW; k++) begin
      if (off_i == OFF_W'(k))      rdata_o = en_q[k*WORD_W +: WORD_W];
      if (off_i == OFF_W'(NW + k)) rdata_o = pend[k*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend;
  end

  assign irq_o = irq_q;

  a_r2_enable_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(off_i) < NW) |=> en_q[WORD_W*int'($past(off_i)) +: WORD_W] == $past(wdata_i));

  a_r4_status_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(off_i) >= NW) |=> $stable(en_q));

  a_r5_irq_needs_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|level_i));

  a_r5_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|en_q));
endmodule

// File: rtl/l1_irq_agg.sv
module l1_irq_agg
  import l1_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned NW     = NUM_SRC / WORD_W,
  localparam int unsigned OFF_W  = $clog2(2 * NW),
  localparam int unsigned BSEL_W = ADDR_W - OFF_W,
  localparam int unsigned MAPPED = NUM_CPU * 2 * NW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_CPU-1:0] irq_o
);
  logic [NUM_SRC-1:0] level;
  logic [BSEL_W-1:0]  bank_sel;
  logic [OFF_W-1:0]   off;
  logic [NUM_CPU-1:0] bank_we;
  word_t              bank_rd [NUM_CPU];

  assign bank_sel = addr_i[ADDR_W-1:OFF_W];
  assign off      = addr_i[OFF_W-1:0];

  l1_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_i),
    .q_o    (level)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    assign bank_we[c] = we_i && (bank_sel == BSEL_W'(c));

    l1_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (level),
      .we_i    (bank_we[c]),
      .off_i   (off),
      .wdata_i (wdata_i),
      .rdata_o (bank_rd[c]),
      .irq_o   (irq_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CPU; c++)
      if (bank_sel == BSEL_W'(c)) rdata_o = bank_rd[c];
  end

  a_r6_single_bank_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_we));

  a_r7_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) >= MAPPED) |-> rdata_o == '0);

  a_r7_unmapped_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(addr_i) >= MAPPED) |-> bank_we == '0);
endmodule

// File: tb/tb_l1_irq_agg.sv
`timescale 1ns/1ps
module tb_l1_irq_agg;
  localparam int NUM_SRC = 64;
  localparam int NUM_CPU = 2;
  localparam int ADDR_W  = 4;
  localparam int NW      = NUM_SRC / 32;
  localparam int BW      = 2 * NW;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [NUM_SRC-1:0] irq_i = '0;
  logic [ADDR_W-1:0]  addr_i = '0;
  logic               we_i = 1'b0;
  logic [31:0]        wdata_i = '0;
  logic [31:0]        rdata_o;
  logic [NUM_CPU-1:0] irq_o;

  int    n_vec = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 0;

  // reference state
  logic [NUM_SRC-1:0] m_en [NUM_CPU];
  logic [NUM_SRC-1:0] m_s1, m_s2;
  logic [NUM_CPU-1:0] m_irq;

  always #2 clk_i = ~clk_i;

  l1_irq_agg #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) dut (
    .clk_i, .rst_ni, .irq_i, .addr_i, .we_i, .wdata_i, .rdata_o, .irq_o
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CPU; c++) m_en[c] = '0;
      m_s1 = '0; m_s2 = '0; m_irq = '0;
    end else begin
      logic [NUM_CPU-1:0] nirq;
      int b, o;
      for (int c = 0; c < NUM_CPU; c++) nirq[c] = |(m_s2 & m_en[c]);
      b = int'(addr_i) / BW;
      o = int'(addr_i) % BW;
      if (we_i && b < NUM_CPU && o < NW) m_en[b][o*32 +: 32] = wdata_i;
      m_s2 = m_s1;
      m_s1 = irq_i;
      m_irq = nirq;
    end
  end

  function automatic logic [31:0] exp_rd(input int a);
    int b, o;
    b = a / BW;
    o = a % BW;
    if (b >= NUM_CPU) return '0;
    if (o < NW) return m_en[b][o*32 +: 32];
    return m_s2[(o-NW)*32 +: 32] & m_en[b][(o-NW)*32 +: 32];
  endfunction

  task automatic compare();
    logic [31:0] er;
    er = exp_rd(int'(addr_i));
    n_vec++;
    if (rdata_o !== er) begin
      n_bad++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, addr_i, rdata_o, er);
    end
    n_vec++;
    if (irq_o !== m_irq) begin
      n_bad++;
      $display("FAIL %s irq_o actual=%b expected=%b", tag, irq_o, m_irq);
    end
  endtask

  task automatic cyc(input int a, input logic w, input logic [31:0] d);
    @(negedge clk_i);
    compare();
    addr_i  = ADDR_W'(a);
    we_i    = w;
    wdata_i = d;
  endtask

  task automatic rd(input int a); cyc(a, 1'b0, '0); endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    tag = "R1";
    for (int a = 0; a < 16; a++) rd(a);
    // R2 / R9 enable write and readback across both banks
    tag = "R2";
    cyc(0, 1, 32'hA5A5_5A5A); cyc(1, 1, 32'h0123_4567);
    cyc(4, 1, 32'hFFFF_0000); cyc(5, 1, 32'h8000_0001);
    for (int a = 0; a < 8; a++) rd(a);
    // R8 single source 33 -> word 1 bit 1
    tag = "R8";
    cyc(1, 1, 32'h0000_0002); cyc(4, 1, 32'h0); cyc(5, 1, 32'h0);
    irq_i = '0; irq_i[33] = 1'b1;
    for (int i = 0; i < 5; i++) rd(3);
    rd(2); rd(7);
    // R3 latency and masking
    tag = "R3";
    cyc(0, 1, 32'h0000_FFFF); cyc(1, 1, 32'hFFFF_FFFF);
    irq_i = {32'h1234_5678, 32'h00F0_F00F};
    for (int i = 0; i < 4; i++) rd(2);
    irq_i = '0;
    for (int i = 0; i < 4; i++) rd(3);
    // R4 status writes ignored
    tag = "R4";
    irq_i = {32'hFFFF_FFFF, 32'hFFFF_FFFF};
    cyc(2, 1, 32'h0); cyc(3, 1, 32'h0); cyc(6, 1, 32'hFFFF_FFFF);
    rd(0); rd(1); rd(2); rd(3); rd(6);
    // R5 irq follows sources and enables
    tag = "R5";
    cyc(4, 1, 32'h0000_0100); rd(6); rd(6); rd(6);
    cyc(4, 1, 32'h0); rd(6); rd(6);
    irq_i = '0; rd(2); rd(2); rd(2); rd(2);
    // R6 bank independence
    tag = "R6";
    cyc(5, 1, 32'hDEAD_BEEF); rd(1); rd(0); rd(5);
    cyc(0, 1, 32'h0F0F_0F0F); rd(4); rd(5);
    // R7 unmapped region
    tag = "R7";
    for (int a = 8; a < 16; a++) cyc(a, 1, 32'hFFFF_FFFF);
    for (int a = 0; a < 16; a++) rd(a);
    // mixed random traffic
    tag = "R5";
    for (int i = 0; i < 400; i++) begin
      if (i % 7 == 0) irq_i = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      cyc(int'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0), $urandom());
    end
    rd(0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule